// File: doc/BRIEF.md
# Vector AES Round Sequencer

This block applies one AES round to a run of 128-bit element groups held in a vector register. Software picks the round flavour (encrypt or decrypt, middle or final), the first 32-bit element and the vector length. The block then walks the selected groups one after another. For each group it reads the round state from the destination register, takes a round key from the key register and writes the new state back into the same destination group. A full cipher is built by issuing the operation once per round with the next round key. The loop over rounds stays in software.

The key for each group comes from one of two places. It can be the key group with the same index, or group 0 broadcast to every group. A separate select lets the key be taken from the destination register itself, so the two operands may overlap. In broadcast mode, key group 0 is latched before the first group is touched. An in-place write to group 0 therefore cannot change the key that later groups use. Both registers are modelled as arrays of groups inside the block. A load port fills them and a read port shows the destination contents.

Every group costs the same three cycles whatever its data. A run of n groups therefore takes a fixed time to finish. The run ends with a single-cycle completion pulse.

Top module: `aesr_vseq`

## Requirements
- R1: Group g holds elements 4g to 4g+3. Byte j of a group sits at bits [8j+7:8j] and is AES state row j mod 4, column j div 4. The shift step moves row r left by r columns on encrypt and right by r columns on decrypt.
- R2: A run updates groups vstart/4 up to vl/4-1 (integer division). Every other destination group keeps its contents.
- R3: With key_bcast=0, group i is combined with key group i.
- R4: With key_bcast=1, every group in the run uses key group 0, latched at the start pulse.
- R5: With key_alias=1, key groups are read from the destination register instead of the key register. With key_bcast=1, the latched group 0 is the value it held before the run, even when the run rewrites group 0.
- R6: mode 00 applies byte substitution, row shift, column mix and key XOR. Mode 01 applies the same without the column mix. Mode 10 applies inverse row shift, inverse substitution, inverse column mix and key XOR. Mode 11 applies the same without the inverse column mix.
- R7: If start is accepted and the run has n>0 groups, done is high in the cycle after the 3n-th rising edge that follows the start edge. busy is high from the cycle after the start edge through the done cycle, independent of data.
- R8: When vl/4 <= vstart/4, done is high in the cycle after the start edge, busy drops the cycle after, and no group changes.
- R9: done lasts exactly one cycle. A start asserted while busy is high is ignored.
- R10: After reset, busy and done are low and every group of both registers reads zero. Loads are taken only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load one group into a register (ignored while busy) |
| ld_key | input | 1 | Load target: 0 destination register, 1 key register |
| ld_idx | input | 3 | Group index for the load |
| ld_data | input | 128 | Group data for the load |
| rd_idx | input | 3 | Destination group shown on rd_data |
| rd_data | output | 128 | Current contents of the selected destination group |
| start | input | 1 | Begin a run (taken only while busy is low) |
| vstart | input | 6 | First 32-bit element of the run |
| vl | input | 6 | Vector length in 32-bit elements, at most 32 |
| key_bcast | input | 1 | 1: broadcast key group 0; 0: key group per index |
| key_alias | input | 1 | 1: read keys from the destination register |
| mode | input | 2 | Round flavour, encoded as in R6 |
| busy | output | 1 | Run in progress, done cycle included |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The assertions take for granted that vl never exceeds four times the group count when a run starts. One assertion checks this input at the start edge. They also assume that nothing but the sequencer writes the destination register while a run is in progress. The bench keeps to this: it issues loads only between runs and chooses every vl within the register. The only time it drives start while busy is high is one deliberate pulse, which the ignore rule must absorb.

// File: rtl/aesr_pkg.sv
package aesr_pkg;

    typedef logic [127:0] grp_t;

    typedef enum logic [1:0] {
        RM_ENC_MID = 2'd0,
        RM_ENC_FIN = 2'd1,
        RM_DEC_MID = 2'd2,
        RM_DEC_FIN = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_READ, SQ_ROUND, SQ_WRITE, SQ_DONE
    } sq_e;

    typedef struct packed {
        grp_t state;
        grp_t key;
    } work_t;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = '0;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    // multiplicative inverse as a^254 through an addition chain; 0 maps to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] a2, a3, a12, a15, a240, a252;
        a2   = gf_mul(a, a);
        a3   = gf_mul(a2, a);
        a12  = gf_mul(gf_mul(a3, a3), gf_mul(a3, a3));
        a15  = gf_mul(a12, a3);
        a240 = gf_mul(a15, a15);
        a240 = gf_mul(a240, a240);
        a240 = gf_mul(a240, a240);
        a240 = gf_mul(a240, a240);
        a252 = gf_mul(a240, a12);
        return gf_mul(a252, a2);
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [7:0] sbox_inv(input logic [7:0] x);
        return gf_inv({x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05);
    endfunction

    function automatic grp_t sub_all(input grp_t s, input logic inv);
        grp_t o;
        for (int j = 0; j < 16; j++)
            o[8*j +: 8] = inv ? sbox_inv(s[8*j +: 8]) : sbox_fwd(s[8*j +: 8]);
        return o;
    endfunction

    function automatic grp_t shift_all(input grp_t s, input logic inv);
        grp_t o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[8*(r+4*c) +: 8] = s[8*(r + 4*(inv ? ((c + 4 - r) % 4) : ((c + r) % 4))) +: 8];
        return o;
    endfunction

    function automatic grp_t mix_all(input grp_t s, input logic inv);
        grp_t o;
        logic [7:0] cf [4];
        logic [7:0] acc;
        cf = inv ? '{8'd14, 8'd11, 8'd13, 8'd9} : '{8'd2, 8'd3, 8'd1, 8'd1};
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                acc = '0;
                for (int k = 0; k < 4; k++)
                    acc = acc ^ gf_mul(cf[(k + 4 - r) % 4], s[8*(k+4*c) +: 8]);
                o[8*(r+4*c) +: 8] = acc;
            end
        return o;
    endfunction

endpackage

// File: rtl/aesr_vreg.sv
module aesr_vreg
    import aesr_pkg::*;
#(
    parameter int NGRP = 8,
    parameter int GIW  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [GIW-1:0]   widx,
    input  grp_t             wdata,
    output grp_t [NGRP-1:0]  q
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst)                            q[g] <= '0;
            else if (we && widx == GIW'(g))     q[g] <= wdata;
        end
    end
endmodule

// File: rtl/aesr_round.sv
module aesr_round
    import aesr_pkg::*;
(
    input  grp_t   st,
    input  grp_t   ky,
    input  rmode_e mode,
    output grp_t   res
);
    logic inv, fin;
    grp_t t0, t1;

    always_comb begin
        inv = (mode == RM_DEC_MID) || (mode == RM_DEC_FIN);
        fin = (mode == RM_ENC_FIN) || (mode == RM_DEC_FIN);
        t0  = inv ? sub_all(shift_all(st, 1'b1), 1'b1)
                  : shift_all(sub_all(st, 1'b0), 1'b0);
        t1  = fin ? t0 : mix_all(t0, inv);
        res = t1 ^ ky;
    end
endmodule

// File: rtl/aesr_seq.sv
module aesr_seq
    import aesr_pkg::*;
#(
    parameter int NGRP = 8,
    parameter int GIW  = 3,
    parameter int EW   = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [EW-1:0]  vstart,
    input  logic [EW-1:0]  vl,
    output sq_e            sq,
    output logic [GIW-1:0] idx,
    output logic           we,
    output logic           busy,
    output logic           done,
    output logic           cap
);
    localparam int GW = EW - 2;

    logic [EW-1:0] first_w, end_w;
    logic [GW-1:0] first_g, end_g, first_q, end_q, idx_q, idx_nx;

    assign first_w = vstart >> 2;
    assign end_w   = vl >> 2;
    assign first_g = GW'(first_w);
    assign end_g   = GW'(end_w);
    assign idx_nx  = idx_q + GW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sq <= SQ_IDLE;
            first_q <= '0;
            end_q <= '0;
            idx_q <= '0;
        end else begin
            case (sq)
                SQ_IDLE: if (start) begin
                    first_q <= first_g;
                    end_q   <= end_g;
                    idx_q   <= first_g;
                    sq      <= (end_g > first_g) ? SQ_READ : SQ_DONE;
                end
                SQ_READ:  sq <= SQ_ROUND;
                SQ_ROUND: sq <= SQ_WRITE;
                SQ_WRITE: begin
                    if (idx_nx == end_q) sq <= SQ_DONE;
                    else begin
                        idx_q <= idx_nx;
                        sq    <= SQ_READ;
                    end
                end
                default:  sq <= SQ_IDLE;
            endcase
        end
    end

    assign idx  = idx_q[GIW-1:0];
    assign we   = (sq == SQ_WRITE);
    assign busy = (sq != SQ_IDLE);
    assign done = (sq == SQ_DONE);
    assign cap  = (sq == SQ_IDLE) && start;

    p_done_one_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        (sq == SQ_READ || sq == SQ_ROUND || sq == SQ_WRITE)
            |-> (idx_q >= first_q && idx_q < end_q));

    p_empty_run_r8: assert property (@(posedge clk) disable iff (rst)
        (cap && end_g <= first_g) |=> (done && !we));

    p_cadence_r7: assert property (@(posedge clk) disable iff (rst)
        we |-> ($past(sq) == SQ_ROUND && $past(sq, 2) == SQ_READ));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: rtl/aesr_vseq.sv
module aesr_vseq
    import aesr_pkg::*;
#(
    parameter int NGRP = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_we,
    input  logic                      ld_key,
    input  logic [$clog2(NGRP)-1:0]   ld_idx,
    input  logic [127:0]              ld_data,
    input  logic [$clog2(NGRP)-1:0]   rd_idx,
    output logic [127:0]              rd_data,
    input  logic                      start,
    input  logic [$clog2(NGRP*4):0]   vstart,
    input  logic [$clog2(NGRP*4):0]   vl,
    input  logic                      key_bcast,
    input  logic                      key_alias,
    input  logic [1:0]                mode,
    output logic                      busy,
    output logic                      done
);
    localparam int GIW = $clog2(NGRP);
    localparam int EW  = $clog2(NGRP*4) + 1;

    sq_e             sq;
    logic [GIW-1:0]  idx;
    logic            seq_we, cap;
    grp_t [NGRP-1:0] dst_q, key_q;
    grp_t            key0_q, res_q, res_w, dst_wd;
    work_t           wk_q;
    rmode_e          mode_q;
    logic            bcast_q, alias_q, dst_we, key_we;
    logic [GIW-1:0]  dst_wi;

    aesr_seq #(.NGRP(NGRP), .GIW(GIW), .EW(EW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .vstart(vstart), .vl(vl),
        .sq(sq), .idx(idx), .we(seq_we), .busy(busy), .done(done), .cap(cap)
    );

    assign dst_we = seq_we | (ld_we & ~ld_key & ~busy);
    assign dst_wi = seq_we ? idx : ld_idx;
    assign dst_wd = seq_we ? res_q : ld_data;
    assign key_we = ld_we & ld_key & ~busy;

    aesr_vreg #(.NGRP(NGRP), .GIW(GIW)) u_dst (
        .clk(clk), .rst(rst), .we(dst_we), .widx(dst_wi), .wdata(dst_wd), .q(dst_q)
    );

    aesr_vreg #(.NGRP(NGRP), .GIW(GIW)) u_key (
        .clk(clk), .rst(rst), .we(key_we), .widx(ld_idx), .wdata(ld_data), .q(key_q)
    );

    aesr_round u_rnd (.st(wk_q.state), .ky(wk_q.key), .mode(mode_q), .res(res_w));

    always_ff @(posedge clk) begin
        if (rst) begin
            key0_q  <= '0;
            wk_q    <= '0;
            res_q   <= '0;
            mode_q  <= RM_ENC_MID;
            bcast_q <= 1'b0;
            alias_q <= 1'b0;
        end else begin
            if (cap) begin
                key0_q  <= key_alias ? dst_q[0] : key_q[0];
                mode_q  <= rmode_e'(mode);
                bcast_q <= key_bcast;
                alias_q <= key_alias;
            end
            if (sq == SQ_READ) begin
                wk_q.state <= dst_q[idx];
                wk_q.key   <= bcast_q ? key0_q : (alias_q ? dst_q[idx] : key_q[idx]);
            end
            if (sq == SQ_ROUND) res_q <= res_w;
        end
    end

    assign rd_data = dst_q[rd_idx];

    p_bcast_key_r4: assert property (@(posedge clk) disable iff (rst)
        (sq == SQ_ROUND && bcast_q) |-> (wk_q.key == key0_q));

    p_key0_hold_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(key0_q));

    p_no_load_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !seq_we) |=> $stable(dst_q));

    always_comb begin
        if (!rst && cap)
            p_vl_limit_r2: assert (vl <= EW'(NGRP*4));
    end
endmodule

// File: tb/sim_aesr_vseq.sv
`timescale 1ns/1ps
module sim_aesr_vseq;
    localparam int NG = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_we = 1'b0, ld_key = 1'b0;
    logic [2:0]   ld_idx = '0, rd_idx = '0;
    logic [127:0] ld_data = '0;
    logic [127:0] rd_data;
    logic         start = 1'b0, key_bcast = 1'b0, key_alias = 1'b0;
    logic [5:0]   vstart = '0, vl = '0;
    logic [1:0]   mode = '0;
    logic         busy, done;

    always #2.5 clk = ~clk;

    aesr_vseq #(.NGRP(NG)) u0 (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_key(ld_key), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data), .start(start),
        .vstart(vstart), .vl(vl), .key_bcast(key_bcast), .key_alias(key_alias),
        .mode(mode), .busy(busy), .done(done)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [7:0]   sb [256];
    logic [7:0]   isb [256];
    logic [127:0] ed [NG];
    logic [127:0] ek [NG];

    task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // substitution table by walking the field with generator 3 and its inverse
    task automatic build_tables();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b0};
            q = q ^ {q[3:0], 4'b0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
        for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
    endtask

    function automatic logic [7:0] xt(logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [127:0] ref_round(logic [127:0] s, logic [127:0] k, logic [1:0] md);
        logic [7:0] a [16];
        logic [7:0] t [16];
        logic [7:0] c0, c1, c2, c3, u, v, all;
        logic [127:0] o;
        for (int j = 0; j < 16; j++) a[j] = s[8*j +: 8];
        if (!md[1]) begin
            for (int j = 0; j < 16; j++) a[j] = sb[a[j]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[r+4*c] = a[r + 4*((c + r) % 4)];
        end else begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[r+4*c] = a[r + 4*((c + 4 - r) % 4)];
            for (int j = 0; j < 16; j++) t[j] = isb[t[j]];
        end
        if (!md[0]) begin
            for (int c = 0; c < 4; c++) begin
                c0 = t[4*c]; c1 = t[4*c+1]; c2 = t[4*c+2]; c3 = t[4*c+3];
                if (md[1]) begin
                    u = xt(xt(c0 ^ c2)); v = xt(xt(c1 ^ c3));
                    c0 = c0 ^ u; c1 = c1 ^ v; c2 = c2 ^ u; c3 = c3 ^ v;
                end
                all = c0 ^ c1 ^ c2 ^ c3;
                t[4*c]   = c0 ^ all ^ xt(c0 ^ c1);
                t[4*c+1] = c1 ^ all ^ xt(c1 ^ c2);
                t[4*c+2] = c2 ^ all ^ xt(c2 ^ c3);
                t[4*c+3] = c3 ^ all ^ xt(c3 ^ c0);
            end
        end
        for (int j = 0; j < 16; j++) o[8*j +: 8] = t[j];
        return o ^ k;
    endfunction

    task automatic load(bit kk, int g, logic [127:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_key = kk; ld_idx = 3'(g); ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
        if (kk) ek[g] = d; else ed[g] = d;
    endtask

    task automatic read_all(string rq);
        for (int g = 0; g < NG; g++) begin
            rd_idx = 3'(g);
            #0.5;
            chk(rq, rd_data, ed[g]);
        end
    endtask

    task automatic run_op(int vs, int vln, bit bc, bit al, logic [1:0] md, bit poke, string rq);
        int first, last_g, n;
        logic [127:0] key0, kk;
        logic [127:0] nd [NG];
        first = vs / 4; last_g = vln / 4;
        n = (last_g > first) ? last_g - first : 0;
        key0 = al ? ed[0] : ek[0];
        nd = ed;
        for (int g = first; g < last_g; g++) begin
            kk = bc ? key0 : (al ? ed[g] : ek[g]);
            nd[g] = ref_round(ed[g], kk, md);
        end
        @(negedge clk);
        vstart = 6'(vs); vl = 6'(vln); key_bcast = bc; key_alias = al; mode = md;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= 3*n; k++) begin
            chk({rq, " R7 busy"}, 128'(busy), 128'(1));
            chk((n == 0) ? {rq, " R8 done"} : {rq, " R7 R9 done"}, 128'(done), 128'(k == 3*n));
            if (poke && k == 1) begin
                start = 1'b1; vstart = 6'd0; vl = 6'd32; mode = ~md;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk({rq, " R9 idle after done"}, {busy, done}, 128'(0));
        ed = nd;
        read_all({rq, " R2 contents"});
    endtask

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset busy/done", {busy, done}, 128'(0));
        for (int g = 0; g < NG; g++) begin ed[g] = '0; ek[g] = '0; end
        read_all("R10 reset contents");

        chk("R6 table 00", 128'(sb[8'h00]), 128'(8'h63));
        chk("R6 table 53", 128'(sb[8'h53]), 128'(8'hed));
        chk("R6 table inv", 128'(isb[8'h16]), 128'(8'hff));

        for (int g = 0; g < NG; g++) begin
            load(1'b0, g, {$urandom, $urandom, $urandom, $urandom});
            load(1'b1, g, {$urandom, $urandom, $urandom, $urandom});
        end
        read_all("R1 loaded contents");

        run_op(0, 32, 1'b0, 1'b0, 2'b00, 1'b0, "R3 R6 enc-mid full");
        run_op(4, 24, 1'b1, 1'b0, 2'b01, 1'b0, "R4 R6 enc-fin bcast part");
        run_op(8, 20, 1'b0, 1'b0, 2'b10, 1'b0, "R3 R6 dec-mid part");
        run_op(0, 32, 1'b1, 1'b1, 2'b11, 1'b0, "R5 R6 dec-fin bcast alias");
        run_op(0, 12, 1'b0, 1'b1, 2'b00, 1'b0, "R5 per-group alias");
        run_op(8, 8, 1'b0, 1'b0, 2'b00, 1'b0, "R8 empty equal");
        run_op(12, 4, 1'b1, 1'b0, 2'b01, 1'b0, "R8 empty reversed");
        run_op(4, 16, 1'b0, 1'b0, 2'b10, 1'b1, "R9 start while busy");
        run_op(2, 7, 1'b1, 1'b0, 2'b11, 1'b0, "R2 unaligned single");
        run_op(28, 32, 1'b1, 1'b1, 2'b00, 1'b0, "R2 R5 last group");

        // loads while busy must be dropped
        @(negedge clk);
        vstart = 6'd0; vl = 6'd4; key_bcast = 1'b0; key_alias = 1'b0; mode = 2'b01;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ld_we = 1'b1; ld_key = 1'b0; ld_idx = 3'd5; ld_data = '1;
        @(negedge clk);
        ld_we = 1'b0;
        repeat (4) @(negedge clk);
        ed[0] = ref_round(ed[0], ek[0], 2'b01);
        read_all("R10 load ignored while busy");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule